// File: doc/BRIEF.md
# Saturating Step-Adjusted DAC Code Register

This block keeps the digital code for one current DAC. Software can load the upper part of the code directly, usually once while the transmitter is being brought up. After that it is expected to move the code in small signed steps. Each step result is checked against a software-programmed ceiling and against zero. When a result falls outside that range, the code saturates at the crossed bound and a sticky warning flag records the event. The warnings never gate the code itself.

The code is one bit wider than the part that is loaded or stepped. The extra bit is the least significant one, and it is supplied with every step write. A chip instantiates the block twice, once for the bias DAC and once for the modulation DAC. Each instance sits behind its own register decode, which drives the write strobes. All updates are registered and appear on the outputs one clock after the strobe.

Top module: `dac_step_code`

## Requirements
- R1: After synchronous reset, `code` is 8 (upper part 4, bit 0 clear), both warning flags are 0, and the ceiling is 255, so an upper value of 255 is accepted without a warning.
- R2: A load write (`set_we`) places `set_data` in `code[8:1]` and leaves `code[0]` unchanged. A value above the held ceiling is replaced by the ceiling and raises `ovf_flag`.
- R3: A step write (`inc_we`) adds `inc_step`, read as a 5-bit two's-complement number from -16 to +15, to `code[8:1]`, and copies `inc_lsb` into `code[0]`.
- R4: A step whose result exceeds the held ceiling leaves `code[8:1]` equal to the ceiling and raises `ovf_flag`.
- R5: A step whose result is below zero leaves `code[8:1]` at 0 and raises `unf_flag`.
- R6: Both flags stay set until `flag_clr`. Setting or clearing a flag never alters `code`.
- R7: When `flag_clr` arrives in the same cycle as a new warning event, the flag ends up 0.
- R8: When `set_we` and `inc_we` arrive together, `code[8:1]` follows the load write and the step value is ignored, while `code[0]` still takes `inc_lsb`.
- R9: A ceiling write (`max_we`) by itself leaves `code` unchanged. A load or step in the same cycle is clamped against the ceiling held before that write.
- R10: In a cycle with neither `set_we` nor `inc_we`, `code` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| set_we | input | 1 | Load-write strobe |
| set_data | input | 8 | Value loaded into the upper code bits |
| max_we | input | 1 | Ceiling-write strobe |
| max_data | input | 8 | New ceiling for the upper code bits |
| inc_we | input | 1 | Step-write strobe |
| inc_step | input | 5 | Signed step, two's complement |
| inc_lsb | input | 1 | Value for code bit 0, taken on a step write |
| flag_clr | input | 1 | Clears both warning flags |
| code | output | 9 | DAC code |
| ovf_flag | output | 1 | Sticky warning: the code was clamped to the ceiling |
| unf_flag | output | 1 | Sticky warning: the code was clamped to zero |

## Verification
The bench uses the default parameters: a 9-bit code, a 5-bit step and a reset upper value of 4. At this size every one of the 32 step values can be tried from starting points spread over the full 8-bit range. The sweep runs under four ceilings: zero, two values in the middle of the range, and full scale. This reaches both saturation bounds, results that land exactly on a bound, and loads that exceed the ceiling. Directed sequences then cover flag persistence, a clear that collides with a new event, a load and a step in the same cycle, and a ceiling write in the same cycle as a step.

// File: rtl/dac_code_pkg.sv
package dac_code_pkg;

    typedef enum logic [1:0] {
        UPD_IDLE = 2'd0,
        UPD_LOAD = 2'd1,
        UPD_STEP = 2'd2
    } upd_kind_e;

    typedef struct packed {
        int   value;
        logic over;
        logic under;
    } clamp_res_t;

    // Saturate a raw candidate into [0, limit] and report which bound was hit.
    function automatic clamp_res_t clamp_to_range(int raw, int limit);
        clamp_res_t r;
        r.value = raw;
        r.over  = 1'b0;
        r.under = 1'b0;
        if (raw < 0) begin
            r.value = 0;
            r.under = 1'b1;
        end else if (raw > limit) begin
            r.value = limit;
            r.over  = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/dac_limit_reg.sv
module dac_limit_reg #(
    parameter int HI_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            max_we,
    input  logic [HI_W-1:0] max_data,
    output logic [HI_W-1:0] limit_q
);
    always_ff @(posedge clk) begin
        if (rst)
            limit_q <= '1;
        else if (max_we)
            limit_q <= max_data;
    end

    // R1: the ceiling leaves reset at full scale
    p_limit_reset_r1: assert property (@(posedge clk)
        $fell(rst) |-> limit_q == '1);
endmodule

// File: rtl/dac_clamp_calc.sv
module dac_clamp_calc
    import dac_code_pkg::*;
#(
    parameter int HI_W   = 8,
    parameter int STEP_W = 5
) (
    input  upd_kind_e         kind,
    input  logic [HI_W-1:0]   cur_hi,
    input  logic [HI_W-1:0]   limit,
    input  logic [HI_W-1:0]   set_data,
    input  logic [STEP_W-1:0] step,
    output logic [HI_W-1:0]   next_hi,
    output logic              ev_over,
    output logic              ev_under
);
    logic signed [STEP_W-1:0] step_s;
    int                       step_i;
    int                       raw;
    clamp_res_t               res;

    always_comb begin
        step_s = $signed(step);
        step_i = int'(step_s);
        case (kind)
            UPD_LOAD: raw = int'(set_data);
            UPD_STEP: raw = int'(cur_hi) + step_i;
            default:  raw = int'(cur_hi);
        endcase
        res      = clamp_to_range(raw, int'(limit));
        next_hi  = res.value[HI_W-1:0];
        ev_over  = (kind != UPD_IDLE) && res.over;
        ev_under = (kind != UPD_IDLE) && res.under;
    end
endmodule

// File: rtl/dac_warn_flags.sv
module dac_warn_flags (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic hit_over,
    input  logic hit_under,
    output logic over_q,
    output logic under_q
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            over_q  <= 1'b0;
            under_q <= 1'b0;
        end else begin
            over_q  <= over_q  | hit_over;
            under_q <= under_q | hit_under;
        end
    end

    // R6: flags persist until cleared
    p_over_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (over_q && !clr) |=> over_q);
    p_under_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (under_q && !clr) |=> under_q);
    // R7: a clear beats an event arriving in the same cycle
    p_clear_wins_r7: assert property (@(posedge clk) disable iff (rst)
        clr |=> (!over_q && !under_q));
endmodule

// File: rtl/dac_step_code.sv
module dac_step_code
    import dac_code_pkg::*;
#(
    parameter int CODE_W = 9,
    parameter int STEP_W = 5,
    parameter int RST_HI = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_we,
    input  logic [CODE_W-2:0] set_data,
    input  logic              max_we,
    input  logic [CODE_W-2:0] max_data,
    input  logic              inc_we,
    input  logic [STEP_W-1:0] inc_step,
    input  logic              inc_lsb,
    input  logic              flag_clr,
    output logic [CODE_W-1:0] code,
    output logic              ovf_flag,
    output logic              unf_flag
);
    localparam int HI_W = CODE_W - 1;

    upd_kind_e       kind;
    logic [HI_W-1:0] hi_q;
    logic            lsb_q;
    logic [HI_W-1:0] limit_q;
    logic [HI_W-1:0] next_hi;
    logic            ev_over;
    logic            ev_under;

    // A load outranks a step for the upper bits
    always_comb begin
        if (set_we)      kind = UPD_LOAD;
        else if (inc_we) kind = UPD_STEP;
        else             kind = UPD_IDLE;
    end

    dac_limit_reg #(.HI_W(HI_W)) u_limit (
        .clk      (clk),
        .rst      (rst),
        .max_we   (max_we),
        .max_data (max_data),
        .limit_q  (limit_q)
    );

    dac_clamp_calc #(.HI_W(HI_W), .STEP_W(STEP_W)) u_calc (
        .kind     (kind),
        .cur_hi   (hi_q),
        .limit    (limit_q),
        .set_data (set_data),
        .step     (inc_step),
        .next_hi  (next_hi),
        .ev_over  (ev_over),
        .ev_under (ev_under)
    );

    dac_warn_flags u_flags (
        .clk       (clk),
        .rst       (rst),
        .clr       (flag_clr),
        .hit_over  (ev_over),
        .hit_under (ev_under),
        .over_q    (ovf_flag),
        .under_q   (unf_flag)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q  <= HI_W'(RST_HI);
            lsb_q <= 1'b0;
        end else begin
            if (kind != UPD_IDLE) hi_q <= next_hi;
            if (inc_we)           lsb_q <= inc_lsb;
        end
    end

    assign code = {hi_q, lsb_q};

    // R2, R4: every update lands at or below the ceiling held beforehand
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
        (set_we || inc_we) |=> code[CODE_W-1:1] <= $past(limit_q));
    // R3: step writes carry code bit 0
    p_lsb_follows_r3: assert property (@(posedge clk) disable iff (rst)
        inc_we |=> code[0] == $past(inc_lsb));
    // R5: an underflow warning appears together with a zeroed upper part
    p_underflow_zero_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(unf_flag) |-> code[CODE_W-1:1] == '0);
    // R10: idle cycles leave the code untouched
    p_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (!set_we && !inc_we) |=> $stable(code));
endmodule

// File: tb/dac_step_code_tb.sv
`timescale 1ns/1ps
module dac_step_code_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic       set_we, max_we, inc_we, inc_lsb, flag_clr;
    logic [7:0] set_data, max_data;
    logic [4:0] inc_step;
    logic [8:0] code;
    logic       ovf_flag, unf_flag;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    int exp_hi, exp_lsb, exp_max;
    bit exp_ovf, exp_unf, last_over, last_under;

    always #2 clk = ~clk;

    dac_step_code u_dut (
        .clk(clk), .rst(rst),
        .set_we(set_we), .set_data(set_data),
        .max_we(max_we), .max_data(max_data),
        .inc_we(inc_we), .inc_step(inc_step), .inc_lsb(inc_lsb),
        .flag_clr(flag_clr),
        .code(code), .ovf_flag(ovf_flag), .unf_flag(unf_flag)
    );

    task automatic check(string tag);
        int ec;
        ec = exp_hi * 2 + exp_lsb;
        n_chk++;
        if (code !== 9'(ec) || ovf_flag !== exp_ovf || unf_flag !== exp_unf) begin
            n_bad++;
            $display("FAIL %s code=%0d ovf=%0b unf=%0b expected code=%0d ovf=%0b unf=%0b",
                     tag, code, ovf_flag, unf_flag, ec, exp_ovf, exp_unf);
        end
    endtask

    // Drive one cycle (called at a falling edge), update the model, return at the next falling edge
    task automatic apply(bit s, int sd, bit m, int md, bit i, int st, bit lb, bit c);
        int raw, old_max, sv;
        set_we = s; set_data = 8'(sd); max_we = m; max_data = 8'(md);
        inc_we = i; inc_step = 5'(st); inc_lsb = lb; flag_clr = c;
        old_max = exp_max;
        last_over = 0; last_under = 0;
        sv = st & 31;
        if (sv >= 16) sv -= 32;
        if (s || i) begin
            raw = s ? sd : exp_hi + sv;
            if (raw < 0) begin raw = 0; last_under = 1; end
            else if (raw > old_max) begin raw = old_max; last_over = 1; end
            exp_hi = raw;
        end
        if (i) exp_lsb = lb;
        if (m) exp_max = md;
        if (c) begin exp_ovf = 0; exp_unf = 0; end
        else begin exp_ovf |= last_over; exp_unf |= last_under; end
        @(negedge clk);
        set_we = 0; max_we = 0; inc_we = 0; flag_clr = 0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int maxes[4] = '{0, 37, 200, 255};
        rst = 1; set_we = 0; max_we = 0; inc_we = 0; flag_clr = 0;
        set_data = 0; max_data = 0; inc_step = 0; inc_lsb = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        exp_hi = 4; exp_lsb = 0; exp_max = 255; exp_ovf = 0; exp_unf = 0;
        check("R1 reset state");
        apply(1, 255, 0, 0, 0, 0, 0, 0);
        check("R1 default ceiling");

        // Sweep: four ceilings, spread starting points, all step values
        foreach (maxes[k]) begin
            apply(0, 0, 1, maxes[k], 0, 0, 0, 0);
            check("R9 ceiling write keeps code");
            for (int start = 0; start < 256; start += 17) begin
                for (int st = 0; st < 32; st++) begin
                    apply(1, start, 0, 0, 0, 0, 0, 1);
                    check("R2/R7 load with clear");
                    apply(0, 0, 0, 0, 1, st, st[0], 0);
                    if (last_over)       check("R4 step clamped to ceiling");
                    else if (last_under) check("R5 step clamped to zero");
                    else                 check("R3 step added");
                end
            end
        end

        // Load above ceiling without clear
        apply(0, 0, 1, 100, 0, 0, 0, 1);
        apply(1, 150, 0, 0, 0, 0, 0, 0);
        check("R2 load above ceiling");
        apply(0, 0, 0, 0, 1, 0, 1, 0);
        check("R6 overflow stays set");
        apply(1, 3, 0, 0, 0, 0, 0, 0);
        apply(0, 0, 0, 0, 1, 5'h1A, 0, 0);
        check("R5 underflow with overflow held R6");
        apply(0, 0, 0, 0, 0, 0, 0, 1);
        check("R6 clear drops both flags");
        apply(0, 0, 0, 0, 1, 5'h10, 1, 1);
        check("R7 clear beats new underflow");
        // Load and step together
        apply(1, 50, 0, 0, 1, 5'h0F, 0, 0);
        check("R8 load wins, bit 0 from step");
        // Ceiling write with step in same cycle uses old ceiling
        apply(0, 0, 1, 40, 1, 5'h0F, 1, 0);
        check("R9 step uses old ceiling");
        apply(0, 0, 0, 0, 1, 0, 1, 0);
        check("R9 new ceiling applies next");
        repeat (3) @(negedge clk);
        check("R10 idle hold");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule